// File: doc/BRIEF.md
# Set-Associative Tag Directory with Access Permissions and Line Locks

This block is the tag and state store of a set-associative cache. It keeps no data. For each way of each set it holds a valid bit, the line address, a two-bit access-permission state and a lock owner context. A controller gives it one operation per cycle on a line-aligned address. The operations are: access check, presence test, availability test, allocate, deallocate, victim probe, permission write, and lock set, clear and test.

All results are combinational from the current state and the request, so they appear in the same cycle. State changes take effect at the next rising clock edge. The set is selected by a contiguous bit field of the address whose low bit is a parameter. Victims are chosen by true least-recently-used order, kept as an age rank per way.

Top module: `tagdir`

## Requirements
- R1: The set index is `addr_i[START_BIT +: log2(SETS)]`. Operations on one set leave every other set unchanged. With defaults, index bits are [3:2] and the bits above bit 3 are the rest of the line address.
- R2: A line is present (hit) only when a valid way holds the exact address and its permission is not NONE. Permission codes: 0 NONE, 1 INVALID, 2 READ_ONLY, 3 READ_WRITE.
- R3: Access check (op 0) on a hit returns success on READ_WRITE for any request type. On READ_ONLY it succeeds only for a load (type 0) or an instruction fetch (type 1), not for a store (type 2). INVALID never succeeds, and a miss returns 0.
- R4: Availability test (op 2) returns 1 when a valid way holds the address with any permission, or when some way is empty or NONE.
- R5: Allocate (op 3) writes the lowest-numbered empty or NONE way, reports it on `way_o`, and sets permission INVALID and the lock to the no-owner value (all ones). It errors if the line is present or no way is free.
- R6: A hit on an access check makes that way most recently used, even when the access is denied. Allocation also makes the written way most recently used.
- R7: Victim probe (op 5) is legal only when the set has no available way. It then returns the stored address of the least recently used way on `victim_addr_o` and its index on `way_o`; otherwise it sets `err_o`.
- R8: Lock set (op 6) stores `ctx_i`, lock clear (op 7) stores all ones, and lock test (op 8) returns 1 only when the stored owner equals `ctx_i`.
- R9: Deallocate (op 4) empties the matching way, after which the line is absent and a later allocation can reuse that way.
- R10: Deallocate, lock, and permission operations on an absent line raise `err_o`, as do failed allocations and undefined op codes (10 to 15). A cycle with `err_o` changes no state.
- R11: Permission write (op 9) stores `perm_i` into the hit way. Writing NONE frees the way for allocation.
- R12: After reset every way is empty, and with `req_valid_i` low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Operation request this cycle |
| op_i | input | 4 | Operation code |
| addr_i | input | ADDR_W | Line-aligned address |
| req_type_i | input | 2 | Access type: 0 load, 1 fetch, 2 store |
| ctx_i | input | CTX_W | Lock owner context |
| perm_i | input | 2 | Permission to write (op 9) |
| resp_o | output | 1 | Operation result |
| err_o | output | 1 | Illegal operation for current state |
| way_o | output | log2(WAYS) | Hit, allocated or victim way |
| victim_addr_o | output | ADDR_W | Address of victim line on a legal probe |

## Verification
A corrupted permission or valid bit shows in the same cycle as a wrong `resp_o` on the next presence or access check of that line. A bad allocation pointer shows at once in `way_o`. A broken age rank stays hidden until the set fills, and then shows as a wrong `victim_addr_o` on the first probe. A lock or state write that lands in the wrong set only shows when that other set is next used. So the bench fills and probes every set, and replays a long mixed stream checked against an arithmetic model of all entries.

// File: rtl/tagdir_pkg.sv
`timescale 1ns/1ps
package tagdir_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_INV  = 2'd1,
    PERM_RO   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  typedef enum logic [3:0] {
    OP_ACCESS   = 4'd0,
    OP_PRESENT  = 4'd1,
    OP_AVAIL    = 4'd2,
    OP_ALLOC    = 4'd3,
    OP_DEALLOC  = 4'd4,
    OP_PROBE    = 4'd5,
    OP_LOCK_SET = 4'd6,
    OP_LOCK_CLR = 4'd7,
    OP_LOCK_TST = 4'd8,
    OP_SET_PERM = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    REQ_LOAD  = 2'd0,
    REQ_FETCH = 2'd1,
    REQ_STORE = 2'd2
  } req_e;
endpackage

// File: rtl/tagdir_set_match.sv
`timescale 1ns/1ps
module tagdir_set_match #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][ADDR_W-1:0] tag_i,
  input  logic [WAYS-1:0][1:0]        perm_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic                        hit_o,
  output logic [$clog2(WAYS)-1:0]     hit_way_o,
  output logic                        free_o,
  output logic [$clog2(WAYS)-1:0]     free_way_o,
  output logic                        tag_seen_o
);
  import tagdir_pkg::*;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] eq_v, hit_v, free_v;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign eq_v[w]   = valid_i[w] && (tag_i[w] == addr_i);
    assign hit_v[w]  = eq_v[w] && (perm_i[w] != PERM_NONE);
    assign free_v[w] = !valid_i[w] || (perm_i[w] == PERM_NONE);
  end

  assign hit_o      = |hit_v;
  assign free_o     = |free_v;
  assign tag_seen_o = |eq_v;

  // lowest index wins
  always_comb begin
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hit_v[w])  hit_way_o  = WAY_W'(w);
      if (free_v[w]) free_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tagdir_lru.sv
`timescale 1ns/1ps
module tagdir_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      touch_i,
  input  logic [$clog2(SETS)-1:0]   touch_set_i,
  input  logic [$clog2(WAYS)-1:0]   touch_way_i,
  input  logic [$clog2(SETS)-1:0]   look_set_i,
  output logic [$clog2(WAYS)-1:0]   victim_way_o
);
  localparam int WAY_W = $clog2(WAYS);

  // age 0 = most recent, WAYS-1 = least recent
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
  logic [WAYS-1:0] is_old;
  logic [WAY_W-1:0] ref_age;

  assign ref_age = age_q[touch_set_i][touch_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < ref_age)
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign is_old[w] = (age_q[look_set_i][w] == WAY_W'(WAYS-1));
  end

  always_comb begin
    victim_way_o = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (is_old[w]) victim_way_o = WAY_W'(w);
  end

  a_r6_touch_mru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(touch_set_i)][$past(touch_way_i)] == '0);

  a_r7_single_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(is_old));
endmodule

// File: rtl/tagdir.sv
`timescale 1ns/1ps
module tagdir #(
  parameter int ADDR_W    = 16,
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  parameter int START_BIT = 2,
  parameter int CTX_W     = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [3:0]              op_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              req_type_i,
  input  logic [CTX_W-1:0]        ctx_i,
  input  logic [1:0]              perm_i,
  output logic                    resp_o,
  output logic                    err_o,
  output logic [$clog2(WAYS)-1:0] way_o,
  output logic [ADDR_W-1:0]       victim_addr_o
);
  import tagdir_pkg::*;

  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int ENTRIES = SETS * WAYS;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam logic [CTX_W-1:0] NO_OWNER = '1;

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][1:0]        perm_q;
  logic [ENTRIES-1:0][CTX_W-1:0]  lock_q;

  logic [SET_W-1:0] set_idx;
  logic [WAYS-1:0]             s_valid;
  logic [WAYS-1:0][ADDR_W-1:0] s_tag;
  logic [WAYS-1:0][1:0]        s_perm;

  logic             hit, free_any, tag_seen;
  logic [WAY_W-1:0] hit_way, free_way, victim_way;
  logic [IDX_W-1:0] hit_idx, free_idx, victim_idx;

  assign set_idx = addr_i[START_BIT +: SET_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      s_valid[w] = valid_q[{set_idx, WAY_W'(w)}];
      s_tag[w]   = tag_q[{set_idx, WAY_W'(w)}];
      s_perm[w]  = perm_q[{set_idx, WAY_W'(w)}];
    end
  end

  tagdir_set_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) i_match (
    .valid_i    (s_valid),
    .tag_i      (s_tag),
    .perm_i     (s_perm),
    .addr_i     (addr_i),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .free_o     (free_any),
    .free_way_o (free_way),
    .tag_seen_o (tag_seen)
  );

  assign hit_idx    = {set_idx, hit_way};
  assign free_idx   = {set_idx, free_way};
  assign victim_idx = {set_idx, victim_way};

  // decode
  logic avail;
  logic touch;
  logic [WAY_W-1:0] touch_way;
  logic do_alloc, do_dealloc, do_lock, do_perm;
  logic [CTX_W-1:0] lock_val;
  perm_e hit_perm;

  assign avail    = tag_seen || free_any;
  assign hit_perm = perm_e'(perm_q[hit_idx]);

  always_comb begin
    resp_o        = 1'b0;
    err_o         = 1'b0;
    way_o         = '0;
    victim_addr_o = '0;
    touch         = 1'b0;
    touch_way     = hit_way;
    do_alloc      = 1'b0;
    do_dealloc    = 1'b0;
    do_lock       = 1'b0;
    do_perm       = 1'b0;
    lock_val      = NO_OWNER;
    if (req_valid_i) begin
      way_o = hit_way;
      case (op_e'(op_i))
        OP_ACCESS: begin
          touch = hit;
          if (hit)
            resp_o = (hit_perm == PERM_RW) ||
                     ((hit_perm == PERM_RO) && (req_type_i != REQ_STORE));
        end
        OP_PRESENT: resp_o = hit;
        OP_AVAIL:   resp_o = avail;
        OP_ALLOC: begin
          way_o     = free_way;
          err_o     = hit || !free_any;
          do_alloc  = !err_o;
          touch     = do_alloc;
          touch_way = free_way;
          resp_o    = !err_o;
        end
        OP_DEALLOC: begin
          err_o      = !hit;
          do_dealloc = hit;
          resp_o     = hit;
        end
        OP_PROBE: begin
          way_o  = victim_way;
          err_o  = avail;
          resp_o = !avail;
          if (!avail) victim_addr_o = tag_q[victim_idx];
        end
        OP_LOCK_SET: begin
          err_o    = !hit;
          do_lock  = hit;
          lock_val = ctx_i;
          resp_o   = hit;
        end
        OP_LOCK_CLR: begin
          err_o   = !hit;
          do_lock = hit;
          resp_o  = hit;
        end
        OP_LOCK_TST: begin
          err_o  = !hit;
          resp_o = hit && (lock_q[hit_idx] == ctx_i);
        end
        OP_SET_PERM: begin
          err_o   = !hit;
          do_perm = hit;
          resp_o  = hit;
        end
        default: err_o = 1'b1;
      endcase
    end
  end

  tagdir_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (touch),
    .touch_set_i  (set_idx),
    .touch_way_i  (touch_way),
    .look_set_i   (set_idx),
    .victim_way_o (victim_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      perm_q  <= '0;
      lock_q  <= '1;
    end else begin
      if (do_alloc) begin
        valid_q[free_idx] <= 1'b1;
        tag_q[free_idx]   <= addr_i;
        perm_q[free_idx]  <= PERM_INV;
        lock_q[free_idx]  <= NO_OWNER;
      end
      if (do_dealloc) valid_q[hit_idx] <= 1'b0;
      if (do_lock)    lock_q[hit_idx]  <= lock_val;
      if (do_perm)    perm_q[hit_idx]  <= perm_i;
    end
  end

  a_r10_error_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && err_o) |=> ($stable(valid_q) && $stable(perm_q) && $stable(lock_q)));

  a_r5_alloc_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == OP_ALLOC && !err_o) |=>
      (valid_q[$past(free_idx)] && perm_q[$past(free_idx)] == PERM_INV &&
       lock_q[$past(free_idx)] == NO_OWNER));

  a_r9_dealloc_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == OP_DEALLOC && !err_o) |=> !valid_q[$past(hit_idx)]);

  a_r7_probe_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == OP_PROBE && !err_o) |-> (!free_any && !tag_seen));

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!resp_o && !err_o && victim_addr_o == '0));
endmodule

// File: tb/test_tagdir.sv
`timescale 1ns/1ps
module test_tagdir;
  localparam int NS = 4, NW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] op = '0;
  logic [15:0] addr = '0;
  logic [1:0] rtype = '0, perm = '0;
  logic [3:0] ctx = '0;
  logic resp, err;
  logic [1:0] way;
  logic [15:0] vaddr;

  always #10 clk = ~clk;

  tagdir i_tagdir (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .op_i(op),
    .addr_i(addr), .req_type_i(rtype), .ctx_i(ctx), .perm_i(perm),
    .resp_o(resp), .err_o(err), .way_o(way), .victim_addr_o(vaddr)
  );

  int n_chk = 0, n_fail = 0;
  logic resp_s, err_s;
  int way_s, vic_s;

  // reference state, index = set*NW + way
  bit mv[NS*NW];
  int mt[NS*NW], mp[NS*NW], ml[NS*NW], mage[NS*NW];

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] la(input int t, input int s);
    return 16'((t << 4) | (s << 2));
  endfunction

  task automatic touch_m(input int s, input int tw);
    int old = mage[s*NW+tw];
    for (int w = 0; w < NW; w++) begin
      if (w == tw) mage[s*NW+w] = 0;
      else if (mage[s*NW+w] < old) mage[s*NW+w]++;
    end
  endtask

  task automatic do_op(input int o, input logic [15:0] a, input int ty,
                       input int cx, input int pm, input string rq);
    int s, hw, fw, vw, e_resp, e_err, e_way, e_vic, b;
    bit seen;
    @(negedge clk);
    req_valid = 1'b1; op = 4'(o); addr = a; rtype = 2'(ty); ctx = 4'(cx); perm = 2'(pm);
    #2;
    s = int'(a[3:2]); hw = -1; fw = -1; vw = 0; seen = 0;
    for (int w = NW-1; w >= 0; w--) begin
      b = s*NW + w;
      if (mv[b] && mt[b] == int'(a) && mp[b] != 0) hw = w;
      if (!mv[b] || mp[b] == 0) fw = w;
      if (mv[b] && mt[b] == int'(a)) seen = 1;
      if (mage[b] == NW-1) vw = w;
    end
    e_resp = 0; e_err = 0; e_vic = 0; e_way = (hw < 0) ? 0 : hw;
    case (o)
      0: if (hw >= 0) e_resp = (mp[s*NW+hw] == 3) || (mp[s*NW+hw] == 2 && ty != 2);
      1: e_resp = (hw >= 0);
      2: e_resp = seen || (fw >= 0);
      3: begin e_way = (fw < 0) ? 0 : fw; e_err = (hw >= 0) || (fw < 0); e_resp = !e_err; end
      4, 6, 7, 9: begin e_err = (hw < 0); e_resp = !e_err; end
      5: begin
        e_way = vw; e_err = seen || (fw >= 0); e_resp = !e_err;
        if (!e_err) e_vic = mt[s*NW+vw];
      end
      8: begin e_err = (hw < 0); e_resp = (hw >= 0) && (ml[s*NW+hw] == cx); end
      default: e_err = 1;
    endcase
    resp_s = resp; err_s = err; way_s = int'(way); vic_s = int'(vaddr);
    chk(rq, int'(resp), e_resp);
    chk(rq, int'(err), e_err);
    chk(rq, int'(way), e_way);
    chk(rq, int'(vaddr), e_vic);
    @(posedge clk);
    if (!e_err) begin
      case (o)
        0: if (hw >= 0) touch_m(s, hw);
        3: begin b = s*NW+fw; mv[b] = 1; mt[b] = int'(a); mp[b] = 1; ml[b] = 15; touch_m(s, fw); end
        4: mv[s*NW+hw] = 0;
        6: ml[s*NW+hw] = cx;
        7: ml[s*NW+hw] = 15;
        9: mp[s*NW+hw] = pm;
        default: ;
      endcase
    end
  endtask

  function automatic string tag_of(input int o);
    case (o)
      0: return "R3";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R9";
      5: return "R7";
      6, 7, 8: return "R8";
      9: return "R11";
      default: return "R10";
    endcase
  endfunction

  bit done = 0;

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < NS*NW; i++) begin
      mv[i] = 0; mt[i] = 0; mp[i] = 0; ml[i] = 15; mage[i] = i % NW;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R12: idle outputs
    chk("R12", int'(resp), 0); chk("R12", int'(err), 0); chk("R12", int'(vaddr), 0);
    for (int s = 0; s < NS; s++) begin
      do_op(1, la(1, s), 0, 0, 0, "R12"); chk("R12", int'(resp_s), 0);
      do_op(2, la(1, s), 0, 0, 0, "R12"); chk("R12", int'(resp_s), 1);
    end

    for (int s = 0; s < NS; s++) begin
      // R1: each set fills from way 0 regardless of others
      for (int t = 1; t <= NW; t++) begin
        do_op(3, la(t, s), 0, 0, 0, "R5");
        chk("R1", way_s, t-1);
      end
      do_op(3, la(5, s), 0, 0, 0, "R10"); chk("R10", int'(err_s), 1);
      do_op(2, la(5, s), 0, 0, 0, "R4");  chk("R4", int'(resp_s), 0);
      do_op(2, la(2, s), 0, 0, 0, "R4");  chk("R4", int'(resp_s), 1);
      do_op(5, la(5, s), 0, 0, 0, "R7");  chk("R7", vic_s, int'(la(1, s)));
      do_op(0, la(1, s), 0, 0, 0, "R3");  chk("R3", int'(resp_s), 0);
      do_op(5, la(5, s), 0, 0, 0, "R6");  chk("R6", vic_s, int'(la(2, s)));
      for (int p = 1; p <= 3; p++)
        for (int ty = 0; ty < 3; ty++) begin
          do_op(9, la(3, s), 0, 0, p, "R11");
          do_op(0, la(3, s), ty, 0, 0, "R3");
          chk("R3", int'(resp_s), (p == 3 || (p == 2 && ty != 2)) ? 1 : 0);
        end
      do_op(8, la(4, s), 0, 15, 0, "R8"); chk("R8", int'(resp_s), 1);
      do_op(6, la(4, s), 0, s+1, 0, "R8");
      do_op(8, la(4, s), 0, s+1, 0, "R8"); chk("R8", int'(resp_s), 1);
      do_op(8, la(4, s), 0, s+2, 0, "R8"); chk("R8", int'(resp_s), 0);
      do_op(7, la(4, s), 0, 0, 0, "R8");
      do_op(8, la(4, s), 0, s+1, 0, "R8"); chk("R8", int'(resp_s), 0);
      do_op(8, la(4, s), 0, 15, 0, "R8");  chk("R8", int'(resp_s), 1);
      do_op(9, la(2, s), 0, 0, 0, "R11");
      do_op(1, la(2, s), 0, 0, 0, "R2");  chk("R2", int'(resp_s), 0);
      do_op(2, la(5, s), 0, 0, 0, "R11"); chk("R11", int'(resp_s), 1);
      do_op(3, la(5, s), 0, 0, 0, "R11"); chk("R11", way_s, 1);
      do_op(4, la(3, s), 0, 0, 0, "R9");
      do_op(1, la(3, s), 0, 0, 0, "R9");  chk("R9", int'(resp_s), 0);
      do_op(4, la(3, s), 0, 0, 0, "R10"); chk("R10", int'(err_s), 1);
      do_op(6, la(3, s), 0, 3, 0, "R10"); chk("R10", int'(err_s), 1);
      do_op(3, la(6, s), 0, 0, 0, "R9");  chk("R9", way_s, 2);
    end

    // mixed stream against the model
    seed = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      int o, t, s;
      seed = seed * 1103515245 + 12345;
      o = (seed >>> 16) & 15; if (o > 10) o = o - 10;
      t = 1 + ((seed >>> 8) & 7) % 6;
      s = (seed >>> 4) & 3;
      do_op(o, la(t, s), (seed >>> 12) % 3 < 0 ? 0 : ((seed >>> 12) & 3) % 3,
            (seed >>> 20) & 3, (seed >>> 24) & 3, tag_of(o));
    end

    @(negedge clk); req_valid = 1'b0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule